// File: doc/BRIEF.md
# Self-Starting Six-State Twisted-Ring Counter

A three-bit synchronous state machine that walks a fixed six-state loop, one state per clock edge: 0, 1, 3, 7, 6, 4 and back to 0. The state is read as an octal digit whose most significant bit is the third flop. The two codes outside the loop, 2 and 5, are steered back into it by a modified next-state term on the top flop. Without that term, the counter would hang in a 2/5 oscillation after a disturbance.

Every flop has its own active-high set line, and a shared active-high clear returns all three to zero. Both act on the clock edge, and clear wins over set. With these lines, software or a test sequence can put the counter into any of the eight codes. A build parameter selects the plain twisted-ring feedback, where the top flop copies the middle one, so the two behaviours can be compared side by side. An asynchronous active-low reset, released through a synchronizer, brings the counter to 0.

Top module: `selfstart_ring_ctr`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 at once, without waiting for a clock edge. After `rst_n` rises, the counter stays at 0 for two further rising edges while the release is synchronized.
- R2: With `clr` low and `set_i` all zero, each rising edge moves a loop state exactly one step along 0→1→3→7→6→4→0, in either build. `state_o[2]` is the MSB, `state_o[1]` the middle bit and `state_o[0]` the LSB.
- R3: With `CORRECTED`=1 and no clear or set, code 2 goes to 1 and code 5 goes to 2 on the next edge. The next-state rule is `state_o[2]` ← (bit0 AND bit1) OR (bit1 AND bit2).
- R4: With `CORRECTED`=0 and no clear or set, `state_o[2]` takes the old `state_o[1]`. As a result, code 2 goes to 5 and code 5 goes back to 2.
- R5: With `CORRECTED`=1, starting from any of the eight codes, the counter is inside the six-state loop after at most two idle edges.
- R6: `clr` high forces `state_o` to 0 on the next edge, whatever `set_i` holds.
- R7: With `clr` low, each bit whose `set_i` line is high reads 1 after the edge. Every other bit takes its normal next-state value.
- R8: Each of the eight codes can be loaded. The sequence is: clear, five idle edges to reach 4, then one edge with `set_i` equal to the target code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of all three flops, active high, wins over set |
| set_i | input | 3 | Synchronous per-flop set, active high, bit k sets flop k |
| state_o | output | 3 | Current state as an octal digit, bit 2 is the MSB |

## Verification
The bench builds two copies of the counter from the same stimulus. One has `CORRECTED`=1 and the other `CORRECTED`=0. Both must follow the same six-state loop, which confirms that the change to the feedback leaves the normal sequence untouched. Only the uncorrected copy can reach the 2/5 lock-up, so that failure mode is observed directly and contrasted with the corrected copy's recovery through 2→1 and 5→2→1.

// File: rtl/ring6_pkg.sv
`timescale 1ns/1ps
package ring6_pkg;
  localparam int RING_BITS  = 3;
  localparam int SYNC_DEPTH = 2;
  localparam int MSB        = RING_BITS - 1;

  typedef logic [RING_BITS-1:0] ring_state_t;

  // Membership of the six-state loop 0,1,3,7,6,4.
  function automatic logic in_loop(input ring_state_t s);
    return (s != ring_state_t'(2)) && (s != ring_state_t'(5));
  endfunction
endpackage

// File: rtl/ring6_rst_sync.sv
`timescale 1ns/1ps
module ring6_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_sync_n = pipe_q[TOP];
endmodule

// File: rtl/ring6_next.sv
`timescale 1ns/1ps
module ring6_next
  import ring6_pkg::*;
#(
  parameter bit CORRECTED = 1'b1
) (
  input  ring_state_t cur,
  output ring_state_t nxt
);
  logic top_d;

  generate
    if (CORRECTED) begin : g_fixed
      // Top flop only rises when the middle flop is high and one neighbour agrees.
      assign top_d = (cur[0] & cur[1]) | (cur[1] & cur[MSB]);
    end else begin : g_plain
      assign top_d = cur[1];
    end
  endgenerate

  always_comb begin
    nxt      = '0;
    nxt[0]   = ~cur[MSB];
    nxt[1]   = cur[0];
    nxt[MSB] = top_d;
  end
endmodule

// File: rtl/ring6_force.sv
`timescale 1ns/1ps
module ring6_force
  import ring6_pkg::*;
(
  input  logic        clr,
  input  ring_state_t set_i,
  input  ring_state_t nxt,
  output ring_state_t d
);
  generate
    for (genvar k = 0; k < RING_BITS; k++) begin : g_bit
      assign d[k] = clr ? 1'b0 : (set_i[k] | nxt[k]);
    end
  endgenerate
endmodule

// File: rtl/ring6_bank.sv
`timescale 1ns/1ps
module ring6_bank
  import ring6_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ring_state_t d,
  output ring_state_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/selfstart_ring_ctr.sv
`timescale 1ns/1ps
module selfstart_ring_ctr
  import ring6_pkg::*;
#(
  parameter bit CORRECTED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] set_i,
  output logic [2:0] state_o
);
  logic        rst_sync_n;
  ring_state_t cur_q;
  ring_state_t step_d;
  ring_state_t load_d;

  ring6_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ring6_next #(.CORRECTED(CORRECTED)) u_next (
    .cur (cur_q),
    .nxt (step_d)
  );

  ring6_force u_force (
    .clr   (clr),
    .set_i (set_i),
    .nxt   (step_d),
    .d     (load_d)
  );

  ring6_bank u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (load_d),
    .q     (cur_q)
  );

  assign state_o = cur_q;
endmodule

// File: rtl/ring6_chk.sv
`timescale 1ns/1ps
module ring6_chk
  import ring6_pkg::*;
#(
  parameter bit CORRECTED = 1'b1
) (
  input logic       clk,
  input logic       rst_raw_n,
  input logic       rst_n,
  input logic       clr,
  input logic [2:0] set_i,
  input logic [2:0] q
);
  logic idle;
  assign idle = !clr && (set_i == 3'd0);

  always @(posedge clk) begin
    if (!rst_raw_n) begin
      p_reset_zero_r1: assert (q == 3'd0) else $error("R1 state not zero in reset");
    end
  end

  p_loop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && in_loop(q)) |=> (in_loop(q) && (q != $past(q))));

  p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == 3'd0));

  p_set_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (set_i != 3'd0)) |=> ((q & $past(set_i)) == $past(set_i)));

  generate
    if (CORRECTED) begin : g_fixed
      p_two_to_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (q == 3'd2)) |=> (q == 3'd1));
      p_five_to_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (q == 3'd5)) |=> (q == 3'd2));
      p_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !in_loop(q)) |=> (q != 3'd5));
    end else begin : g_plain
      p_lockup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !in_loop(q)) |=> (!in_loop(q) && (q != $past(q))));
    end
  endgenerate
endmodule

bind selfstart_ring_ctr ring6_chk #(.CORRECTED(CORRECTED)) u_chk (
  .clk       (clk),
  .rst_raw_n (rst_n),
  .rst_n     (rst_sync_n),
  .clr       (clr),
  .set_i     (set_i),
  .q         (state_o)
);

// File: tb/selfstart_ring_ctr_bench.sv
`timescale 1ns/1ps
module selfstart_ring_ctr_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic [2:0] set_i;
  logic [2:0] q_fix;
  logic [2:0] q_raw;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  selfstart_ring_ctr #(.CORRECTED(1'b1)) u_selfstart_ring_ctr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .set_i(set_i), .state_o(q_fix));

  selfstart_ring_ctr #(.CORRECTED(1'b0)) u_selfstart_ring_ctr_raw (
    .clk(clk), .rst_n(rst_n), .clr(clr), .set_i(set_i), .state_o(q_raw));

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [2:0] s);
    @(negedge clk);
    clr   = c;
    set_i = s;
    @(posedge clk);
    #1;
  endtask

  // Clear, then five idle edges: 0,1,3,7,6,4 in both builds.
  task automatic park_at_four();
    step(1'b1, 3'd0);
    for (int i = 0; i < 5; i++) step(1'b0, 3'd0);
  endtask

  task automatic force_to(input logic [2:0] t);
    park_at_four();
    step(1'b0, t);
  endtask

  task automatic t_reset_r1();
    check("R1 fixed in reset", q_fix, 3'd0);
    check("R1 raw in reset", q_raw, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R1 held during sync release", q_fix, 3'd0);
    // Mid-run asynchronous reset
    step(1'b1, 3'd0);
    step(1'b0, 3'd0);
    step(1'b0, 3'd0);
    check("R2 reached 3 before reset", q_fix, 3'd3);
    #4;
    rst_n = 1'b0;
    #1;
    check("R1 async fixed", q_fix, 3'd0);
    check("R1 async raw", q_raw, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R1 still zero after two edges", q_raw, 3'd0);
  endtask

  task automatic t_loop_r2();
    logic [2:0] seq [6] = '{3'd1, 3'd3, 3'd7, 3'd6, 3'd4, 3'd0};
    step(1'b1, 3'd0);
    check("R2 start", q_fix, 3'd0);
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 3'd0);
      check("R2 fixed loop", q_fix, seq[i % 6]);
      check("R2 raw loop", q_raw, seq[i % 6]);
    end
  endtask

  task automatic t_force_r8();
    for (int t = 0; t < 8; t++) begin
      force_to(3'(t));
      check("R8 fixed load", q_fix, 3'(t));
      check("R8 raw load", q_raw, 3'(t));
    end
  endtask

  task automatic t_fixed_r3();
    force_to(3'd2);
    step(1'b0, 3'd0);
    check("R3 2 to 1", q_fix, 3'd1);
    force_to(3'd5);
    step(1'b0, 3'd0);
    check("R3 5 to 2", q_fix, 3'd2);
    step(1'b0, 3'd0);
    check("R3 then to 1", q_fix, 3'd1);
  endtask

  task automatic t_raw_r4();
    force_to(3'd2);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 3'd0);
      check("R4 raw lock-up", q_raw, (i % 2 == 0) ? 3'd5 : 3'd2);
    end
  endtask

  task automatic t_recover_r5();
    for (int t = 0; t < 8; t++) begin
      force_to(3'(t));
      step(1'b0, 3'd0);
      step(1'b0, 3'd0);
      checks++;
      if (q_fix == 3'd2 || q_fix == 3'd5) begin
        errors++;
        $display("FAIL R5 from %0d actual=%0d expected=loop state", t, q_fix);
      end
    end
  endtask

  task automatic t_clr_r6();
    force_to(3'd7);
    step(1'b1, 3'b111);
    check("R6 clr beats set fixed", q_fix, 3'd0);
    check("R6 clr beats set raw", q_raw, 3'd0);
  endtask

  task automatic t_set_r7();
    step(1'b1, 3'd0);
    step(1'b0, 3'b100);
    check("R7 set msb from 0", q_fix, 3'd5);
    step(1'b1, 3'd0);
    step(1'b0, 3'd0);
    step(1'b0, 3'd0);
    step(1'b0, 3'b001);
    check("R7 set lsb from 3", q_fix, 3'd7);
    park_at_four();
    step(1'b0, 3'b010);
    check("R7 set middle from 4", q_raw, 3'd2);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    set_i = 3'd0;
    #5;
    t_reset_r1();
    t_loop_r2();
    t_force_r8();
    t_fixed_r3();
    t_raw_r4();
    t_recover_r5();
    t_clr_r6();
    t_set_r7();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule